// File: doc/BRIEF.md
# Multicart CHR Bank Address Composer

This block sits between an MMC3-style banking core and the pattern memory of a multicart. For each PPU fetch it takes the three PPU address bits that name a 1 KB window (bits 12:10) and returns the final 1 KB CHR page number, together with a flag that steers the fetch to the on-cart 8 KB CHR RAM instead of CHR ROM. The MMC3 core supplies its command register and its six CHR bank values. The multicart supplies five expansion registers: a mode register, an outer-base register, a feature register and two extra bank registers.

Three layouts exist. In the whole-bank layout the 8 KB pattern space is one bank, numbered by the outer-base register ORed with a 2-bit latch that CPU writes to the upper half of the CPU address space can load. In the RAM-redirect layout each 1 KB window keeps its ordinary MMC3 bank and is sent to CHR RAM. In the base layout an outer base is ORed into every MMC3 bank. Four 1 KB windows in one pattern table can optionally take their banks from registers directly.

The mapping is purely combinational apart from the 2-bit latch, so no handshake applies: the page is valid in the same cycle as the PPU address, and nothing can back-pressure a PPU fetch. Control inputs are plain levels and the write strobe is a single-cycle pulse.

Top module: `chr_bank_composer`

## Requirements
- R1: When mode register bit 6 is 1, the page is {outer_reg OR latch, ppu_win} (the 8-bit bank followed by the 3 PPU window bits) and the RAM flag is 0, whatever the other bits hold.
- R2: A cycle with hi_wr_i high while mode bit 6 is 1 and mode bits 5 and 4 are both 0 loads wr_data_i[1:0] into the latch; the new value shows on the page from the cycle after that clock edge.
- R3: A cycle with hi_wr_i high while mode bit 6 is 1 and mode bit 5 or bit 4 is 1 clears the latch to 0.
- R4: A cycle with hi_wr_i high while mode bit 6 is 0 leaves the latch unchanged.
- R5: The latch is 0 after reset.
- R6: When mode bit 6 is 0 and mode bit 5 is 1, the RAM flag is 1 and the page is the standard MMC3 bank of the window with only its low 3 bits kept; all upper page bits are 0.
- R7: When mode bits 6 and 5 are both 0, the RAM flag is 0 and the page is the window's MMC3 bank ORed with (outer_reg AND 0x7F) shifted left by 3. Outer bit 7 is ignored here.
- R8: Standard MMC3 mapping: with w = ppu_win XOR {cmd bit 7, 2'b00}, windows w=0..3 use the 2 KB banks R0 and R1 (even page for w even, low bit forced to 1 for w odd), and windows w=4..7 use R2..R5. Bank Rn sits at mmc3_bank_i[8n+7:8n].
- R9: In the base layout with feature register bit 1 set, windows with w=0,1,2,3 take R0, extra register A, R1 and extra register B as full 1 KB values. Windows w=4..7 keep the standard mapping.
- R10: Command bit 7 moves the four overridden windows to the other pattern table, so with bit 7 set they are PPU windows 4..7. The override does not apply in the RAM-redirect layout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ppu_win_i | input | 3 | PPU address bits 12:10 |
| mmc3_cmd_i | input | 8 | MMC3 command register (bit 7 inverts the CHR tables) |
| mmc3_bank_i | input | 48 | MMC3 CHR bank values R0..R5, R0 in the low byte |
| mode_reg_i | input | 8 | Mode expansion register (bits 6, 5, 4 used) |
| outer_reg_i | input | 8 | Outer-base / whole-bank register |
| feat_reg_i | input | 8 | Feature register (bit 1 enables the window override) |
| extra_a_i | input | 8 | Override bank for the second overridden window |
| extra_b_i | input | 8 | Override bank for the fourth overridden window |
| hi_wr_i | input | 1 | One-cycle strobe for a CPU write in the upper address half |
| wr_data_i | input | 8 | CPU write data |
| chr_page_o | output | 11 | Final 1 KB CHR page number |
| chr_ram_sel_o | output | 1 | 1 selects CHR RAM, 0 selects CHR ROM |

## Verification
The mapping is swept over all eight PPU windows, both values of command bit 7, and the whole-bank, RAM-redirect, plain base and overridden base layouts, using three sets of bank values. Each bank register holds a distinct pattern, so a window that picks the wrong register, drops the 2 KB low-bit rule, or misses the table inversion gives a different page. Outer values with bit 7 set tell the whole-bank use of that bit from its masking in the base layout. The latch is driven through loads, clears with each of mode bits 4 and 5, ignored writes and a reset. It is read back through the whole-bank page.

// File: rtl/chr_comp_pkg.sv
package chr_comp_pkg;

  typedef enum logic [1:0] {
    MODE_WHOLE8K = 2'd0,
    MODE_RAMWIN  = 2'd1,
    MODE_BASE    = 2'd2
  } chr_mode_e;

  // Whole-bank layout wins over RAM redirect, which wins over base layout.
  function automatic chr_mode_e pick_mode(input logic whole, input logic ram);
    if (whole)    return MODE_WHOLE8K;
    else if (ram) return MODE_RAMWIN;
    else          return MODE_BASE;
  endfunction

endpackage

// File: rtl/chr_latch.sv
module chr_latch #(
  parameter int LATCH_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_i,
  input  logic               whole_i,
  input  logic               clr_i,
  input  logic [LATCH_W-1:0] data_i,
  output logic [LATCH_W-1:0] latch_o
);

  logic take;
  assign take = wr_i && whole_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    latch_o <= '0;
    else if (take) latch_o <= clr_i ? '0 : data_i;
  end

  AST_LATCH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && whole_i && !clr_i) |=> (latch_o == $past(data_i)));  // R2
  AST_LATCH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && whole_i && clr_i) |=> (latch_o == '0));  // R3
  AST_LATCH_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_i && whole_i) |=> $stable(latch_o));  // R4

endmodule

// File: rtl/chr_win_select.sv
module chr_win_select #(
  parameter  int BANK_W   = 8,
  parameter  int WIN_BITS = 3,
  localparam int NWIN     = 1 << WIN_BITS,
  localparam int HALF     = NWIN / 2,
  localparam int NPAIR    = HALF / 2,
  localparam int NBANK    = NPAIR + HALF
) (
  input  logic [WIN_BITS-1:0]     ppu_win_i,
  input  logic                    swap_i,
  input  logic [NBANK*BANK_W-1:0] bank_flat_i,
  input  logic                    ovr_en_i,
  input  logic [HALF*BANK_W-1:0]  ovr_flat_i,
  output logic [BANK_W-1:0]       bank_o
);

  logic [WIN_BITS-1:0] win;
  logic [BANK_W-1:0]   std_tab [NWIN];
  logic [BANK_W-1:0]   ovr_tab [HALF];

  // Table inversion flips the top window bit.
  assign win = ppu_win_i ^ {swap_i, {(WIN_BITS-1){1'b0}}};

  generate
    for (genvar w = 0; w < NWIN; w++) begin : g_std
      if (w < HALF) begin : g_pair
        // 2 KB banks: even register value, low bit picks the half.
        assign std_tab[w] = {bank_flat_i[(w/2)*BANK_W + 1 +: BANK_W-1], (w % 2 == 1)};
      end else begin : g_single
        assign std_tab[w] = bank_flat_i[(w - HALF + NPAIR)*BANK_W +: BANK_W];
      end
    end
    for (genvar h = 0; h < HALF; h++) begin : g_ovr
      assign ovr_tab[h] = ovr_flat_i[h*BANK_W +: BANK_W];
    end
  endgenerate

  always_comb begin
    bank_o = std_tab[win];
    if (ovr_en_i && !win[WIN_BITS-1]) bank_o = ovr_tab[win[WIN_BITS-2:0]];
  end

endmodule

// File: rtl/chr_page_merge.sv
module chr_page_merge
  import chr_comp_pkg::*;
#(
  parameter  int BANK_W        = 8,
  parameter  int WIN_BITS      = 3,
  parameter  int LATCH_W       = 2,
  parameter  int RAM_PAGE_BITS = 3,
  parameter  int BASE_BITS     = 7,
  localparam int PAGE_W        = BANK_W + WIN_BITS
) (
  input  chr_mode_e           mode_i,
  input  logic [WIN_BITS-1:0] ppu_win_i,
  input  logic [BANK_W-1:0]   bank_i,
  input  logic [LATCH_W-1:0]  latch_i,
  input  logic [BANK_W-1:0]   outer_i,
  output logic [PAGE_W-1:0]   page_o,
  output logic                ram_sel_o
);

  logic [BANK_W-1:0] whole_bank;
  logic [PAGE_W-1:0] base_add;

  assign whole_bank = outer_i | {{(BANK_W-LATCH_W){1'b0}}, latch_i};
  assign base_add   = PAGE_W'(outer_i[BASE_BITS-1:0]) << WIN_BITS;

  always_comb begin
    page_o    = '0;
    ram_sel_o = 1'b0;
    case (mode_i)
      MODE_WHOLE8K: page_o = {whole_bank, ppu_win_i};
      MODE_RAMWIN: begin
        page_o    = PAGE_W'(bank_i[RAM_PAGE_BITS-1:0]);
        ram_sel_o = 1'b1;
      end
      default:      page_o = PAGE_W'(bank_i) | base_add;
    endcase
  end

endmodule

// File: rtl/chr_bank_composer.sv
module chr_bank_composer
  import chr_comp_pkg::*;
#(
  parameter  int BANK_W        = 8,
  parameter  int WIN_BITS      = 3,
  parameter  int LATCH_W       = 2,
  parameter  int RAM_PAGE_BITS = 3,
  parameter  int BASE_BITS     = 7,
  localparam int NWIN          = 1 << WIN_BITS,
  localparam int NBANK         = NWIN / 4 + NWIN / 2,
  localparam int PAGE_W        = BANK_W + WIN_BITS
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [WIN_BITS-1:0]     ppu_win_i,
  input  logic [BANK_W-1:0]       mmc3_cmd_i,
  input  logic [NBANK*BANK_W-1:0] mmc3_bank_i,
  input  logic [BANK_W-1:0]       mode_reg_i,
  input  logic [BANK_W-1:0]       outer_reg_i,
  input  logic [BANK_W-1:0]       feat_reg_i,
  input  logic [BANK_W-1:0]       extra_a_i,
  input  logic [BANK_W-1:0]       extra_b_i,
  input  logic                    hi_wr_i,
  input  logic [BANK_W-1:0]       wr_data_i,
  output logic [PAGE_W-1:0]       chr_page_o,
  output logic                    chr_ram_sel_o
);

  chr_mode_e          mode;
  logic [LATCH_W-1:0] latch;
  logic [BANK_W-1:0]  win_bank;
  logic [4*BANK_W-1:0] ovr_flat;

  assign mode     = pick_mode(mode_reg_i[6], mode_reg_i[5]);
  // Override order over the four windows: R0, extra A, R1, extra B.
  assign ovr_flat = {extra_b_i, mmc3_bank_i[BANK_W +: BANK_W], extra_a_i, mmc3_bank_i[0 +: BANK_W]};

  chr_latch #(.LATCH_W(LATCH_W)) u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (hi_wr_i),
    .whole_i (mode_reg_i[6]),
    .clr_i   (|mode_reg_i[5:4]),
    .data_i  (wr_data_i[LATCH_W-1:0]),
    .latch_o (latch)
  );

  chr_win_select #(.BANK_W(BANK_W), .WIN_BITS(WIN_BITS)) u_sel (
    .ppu_win_i   (ppu_win_i),
    .swap_i      (mmc3_cmd_i[7]),
    .bank_flat_i (mmc3_bank_i),
    .ovr_en_i    (feat_reg_i[1] && mode == MODE_BASE),
    .ovr_flat_i  (ovr_flat),
    .bank_o      (win_bank)
  );

  chr_page_merge #(
    .BANK_W(BANK_W), .WIN_BITS(WIN_BITS), .LATCH_W(LATCH_W),
    .RAM_PAGE_BITS(RAM_PAGE_BITS), .BASE_BITS(BASE_BITS)
  ) u_merge (
    .mode_i    (mode),
    .ppu_win_i (ppu_win_i),
    .bank_i    (win_bank),
    .latch_i   (latch),
    .outer_i   (outer_reg_i),
    .page_o    (chr_page_o),
    .ram_sel_o (chr_ram_sel_o)
  );

  AST_WHOLE_ROM: assert property (@(posedge clk) disable iff (!rst_n)
    mode_reg_i[6] |-> (!chr_ram_sel_o && chr_page_o[WIN_BITS-1:0] == ppu_win_i));  // R1
  AST_RAM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    chr_ram_sel_o |-> (chr_page_o[PAGE_W-1:RAM_PAGE_BITS] == '0));  // R6
  AST_RAM_ONLY_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    chr_ram_sel_o |-> (!mode_reg_i[6] && mode_reg_i[5]));  // R6
  AST_BASE_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_reg_i[6] && !mode_reg_i[5]) |->
      ((chr_page_o[WIN_BITS +: BASE_BITS] & outer_reg_i[BASE_BITS-1:0]) == outer_reg_i[BASE_BITS-1:0]));  // R7
  AST_OVR_EXTRA_A: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_reg_i[6] && !mode_reg_i[5] && feat_reg_i[1] &&
     ppu_win_i == {mmc3_cmd_i[7], {(WIN_BITS-2){1'b0}}, 1'b1}) |->
      ((chr_page_o[BANK_W-1:0] & extra_a_i) == extra_a_i));  // R9

endmodule

// File: tb/chr_bank_composer_tb_top.sv
module chr_bank_composer_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  ppu_win = '0;
  logic [7:0]  cmd = '0;
  logic [47:0] banks = '0;
  logic [7:0]  mode_r = '0, outer_r = '0, feat_r = '0, ext_a = '0, ext_b = '0;
  logic        hi_wr = 1'b0;
  logic [7:0]  wdata = '0;
  logic [10:0] page;
  logic        ram_sel;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;
  logic [1:0] lat_model = 2'd0;

  always #2 clk = ~clk;

  chr_bank_composer dut_i (
    .clk(clk), .rst_n(rst_n), .ppu_win_i(ppu_win), .mmc3_cmd_i(cmd),
    .mmc3_bank_i(banks), .mode_reg_i(mode_r), .outer_reg_i(outer_r),
    .feat_reg_i(feat_r), .extra_a_i(ext_a), .extra_b_i(ext_b),
    .hi_wr_i(hi_wr), .wr_data_i(wdata), .chr_page_o(page), .chr_ram_sel_o(ram_sel)
  );

  function automatic logic [7:0] rb(input int n);
    return banks[n*8 +: 8];
  endfunction

  // Expected {ram_sel, page} from the requirements.
  function automatic logic [11:0] expect_out(input logic [2:0] p);
    logic [2:0]  w;
    logic [7:0]  b;
    logic [10:0] pg;
    w = p ^ {cmd[7], 2'b00};
    case (w)
      3'd0: b = rb(0) & 8'hFE;
      3'd1: b = rb(0) | 8'h01;
      3'd2: b = rb(1) & 8'hFE;
      3'd3: b = rb(1) | 8'h01;
      default: b = rb(int'(w) - 2);
    endcase
    if (mode_r[6]) begin
      pg = {outer_r | {6'd0, lat_model}, p};
      return {1'b0, pg};
    end else if (mode_r[5]) begin
      return {1'b1, 8'd0, b[2:0]};
    end else begin
      if (feat_r[1] && !w[2]) begin
        case (w[1:0])
          2'd0: b = rb(0);
          2'd1: b = ext_a;
          2'd2: b = rb(1);
          default: b = ext_b;
        endcase
      end
      pg = {3'd0, b} | ({4'd0, outer_r[6:0]} << 3);
      return {1'b0, pg};
    end
  endfunction

  task automatic check_win(input string req, input logic [2:0] p);
    logic [11:0] exp_v;
    @(negedge clk);
    ppu_win = p;
    #1;
    exp_v = expect_out(p);
    n_checks++;
    if ({ram_sel, page} !== exp_v) begin
      n_fail++;
      $display("FAIL %s: mode=%h cmd7=%0d win=%0d got ram=%0d page=%h expected ram=%0d page=%h",
               req, mode_r, cmd[7], p, ram_sel, page, exp_v[11], exp_v[10:0]);
    end
  endtask

  task automatic hi_write(input logic [7:0] d);
    @(negedge clk);
    hi_wr = 1'b1;
    wdata = d;
    @(negedge clk);
    hi_wr = 1'b0;
    if (mode_r[6]) lat_model = (|mode_r[5:4]) ? 2'd0 : d[1:0];
  endtask

  task automatic latch_probe(input string req);
    logic [7:0] keep_mode;
    keep_mode = mode_r;
    @(negedge clk);
    mode_r = 8'h40;
    check_win(req, 3'd5);
    mode_r = keep_mode;
  endtask

  task automatic load_set(input int s);
    case (s)
      0: begin banks = {8'h55, 8'h44, 8'h33, 8'h22, 8'h11, 8'h00}; ext_a = 8'h66; ext_b = 8'h77; outer_r = 8'h05; end
      1: begin banks = {8'h0F, 8'hF0, 8'h7E, 8'h81, 8'h3C, 8'hA5}; ext_a = 8'hC3; ext_b = 8'h18; outer_r = 8'hFF; end
      default: begin banks = {8'h96, 8'h2B, 8'hD4, 8'h69, 8'h5A, 8'hE7}; ext_a = 8'h0B; ext_b = 8'hB0; outer_r = 8'h88; end
    endcase
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R5: latch zero out of reset, seen through the whole-bank page
    mode_r = 8'h40; outer_r = 8'h00;
    for (int p = 0; p < 8; p++) check_win("R5", 3'(p));

    // R2: loads
    hi_write(8'hF3);
    check_win("R2", 3'd0);
    outer_r = 8'h10;
    check_win("R2", 3'd6);
    hi_write(8'h01);
    check_win("R2", 3'd2);

    // R3: clear by bit 4, then by bit 5
    hi_write(8'h02);
    mode_r = 8'h50; hi_write(8'h03);
    latch_probe("R3");
    mode_r = 8'h40; hi_write(8'h03);
    mode_r = 8'h60; hi_write(8'h01);
    latch_probe("R3");

    // R4: write with whole-bank off is ignored
    mode_r = 8'h40; outer_r = 8'h00; hi_write(8'h02);
    mode_r = 8'h00; hi_write(8'h01);
    latch_probe("R4");
    mode_r = 8'h20; hi_write(8'h03);
    latch_probe("R4");

    // R5: reset clears a loaded latch
    mode_r = 8'h40; hi_write(8'h03);
    check_win("R2", 3'd1);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1; lat_model = 2'd0;
    check_win("R5", 3'd1);

    // R1, R6, R7, R8, R9, R10: full sweep
    mode_r = 8'h40; hi_write(8'h02);
    for (int s = 0; s < 3; s++) begin
      load_set(s);
      for (int m = 0; m < 5; m++) begin
        case (m)
          0: begin mode_r = 8'h40; feat_r = 8'h02; end   // R1
          1: begin mode_r = 8'h20; feat_r = 8'h00; end   // R6
          2: begin mode_r = 8'h30; feat_r = 8'h02; end   // R6, R10
          3: begin mode_r = 8'h00; feat_r = 8'h00; end   // R7, R8
          default: begin mode_r = 8'h00; feat_r = 8'h02; end // R9
        endcase
        for (int c = 0; c < 2; c++) begin
          cmd = c[0] ? 8'h80 : 8'h05;
          for (int p = 0; p < 8; p++) begin
            case (m)
              0: check_win("R1", 3'(p));
              1: check_win("R6", 3'(p));
              2: check_win("R10", 3'(p));
              3: check_win(c[0] ? "R8" : "R7", 3'(p));
              default: check_win(c[0] ? "R10" : "R9", 3'(p));
            endcase
          end
        end
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule